// File: doc/BRIEF.md
# TID-Routed Stream Splitter with Scalar Capture

This block takes one 128-bit AXI4-Stream whose beats carry a 3-bit TID and steers each beat to one of eight output lanes, lane k for TID k. Data and TLAST go to every lane at once. Only the TVALID of the selected lane is raised, and the input TREADY is taken from that lane. The block is used on the feed path of a stream accelerator. Lane 0 carries bulk data and the other lanes carry side streams.

Parameter `TID1_OUTPUT` sets what lane 1 does. A value of 1 keeps it as an ordinary stream lane. A value of 2 unpacks TID 1 beats into `NUM_SCALARS` (1 to 8) scalar registers. Each scalar has a width in `SCALAR_WIDTHS` that is a multiple of 32 bits. Scalar registers are laid out at a pitch of `SCALAR_MAX_W` bits on a flat output bus, with scalar k at `scalar_o[k*SCALAR_MAX_W +: SCALAR_MAX_W]`.

Parameter `EN_AP_CTRL_HS` = 1 adds a small AXI4-Lite register set. It drives the start/done/idle/ready handshake of an attached accelerator and raises an interrupt on completion.

Top module: `tid_stream_router`

## Requirements
- R1: For a valid beat with TID k, `m_tvalid` is the one-hot bit k, except for TID 1 in scalar mode. `m_tvalid` is all zero while `s_tvalid` is low. `m_tdata` and `m_tlast` equal `s_tdata` and `s_tlast`.
- R2: `s_tready` equals `m_tready[s_tid]` for every TID that is routed to a stream lane.
- R3: In scalar mode (`TID1_OUTPUT`=2), a TID 1 beat sees `s_tready`=1 whatever `m_tready` is, and `m_tvalid[1]` is never raised.
- R4: Scalars are filled in index order starting at scalar 0. Scalar k takes ceil(width_k/128) accepted TID 1 beats. The first beat lands in the least significant 128 bits. Beat bits beyond width_k, and all slot bits above width_k, read as zero.
- R5: Scalar registers reset to zero. A scalar changes only on the clock edge that accepts its final beat, so a partly filled value is never visible. Beats with other TIDs do not disturb filling.
- R6: After the last scalar is filled, the next TID 1 beat starts scalar 0 again. A TID 1 beat with TLAST ends the fill: a complete scalar commits, a partial one is discarded, and the next beat starts scalar 0.
- R7: After reset, `ap_start`, `interrupt`, `bvalid`, `rvalid` and all scalars are 0.
- R8: A write to offset 0x0 with bit 0 set raises `ap_start`. Writing 0 to bit 0 does not clear it. Bit 7 of that write stores the auto-restart flag. `ap_start` falls on the edge after `ap_ready` is sampled high, unless auto-restart is set.
- R9: Reading offset 0x0 returns start in bit 0, latched done in bit 1, `ap_idle` in bit 2, `ap_ready` in bit 3 and auto-restart in bit 7. The done bit sets on `ap_done` and clears when the register is read. `interrupt` follows the done bit.
- R10: With `EN_AP_CTRL_HS`=0, `ap_start`, `interrupt` and every AXI4-Lite ready and valid output stay at 0.
- R11: With `TID1_OUTPUT`=1, TID 1 beats go to lane 1 with `s_tready` = `m_tready[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | DATA_W | Input stream data |
| s_tid | input | TID_W | Input stream TID, selects the lane |
| s_tlast | input | 1 | Input end of packet |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat ready |
| m_tdata | output | DATA_W | Data, shared by all lanes |
| m_tlast | output | 1 | TLAST, shared by all lanes |
| m_tvalid | output | NUM_LANES | Per-lane valid |
| m_tready | input | NUM_LANES | Per-lane ready |
| scalar_o | output | NUM_SCALARS*SCALAR_MAX_W | Captured scalar registers |
| cfg_awaddr | input | ADDR_W | Write address |
| cfg_awvalid | input | 1 | Write address valid |
| cfg_awready | output | 1 | Write address ready |
| cfg_wdata | input | 32 | Write data |
| cfg_wstrb | input | 4 | Write byte strobes |
| cfg_wvalid | input | 1 | Write data valid |
| cfg_wready | output | 1 | Write data ready |
| cfg_bresp | output | 2 | Write response (always OKAY) |
| cfg_bvalid | output | 1 | Write response valid |
| cfg_bready | input | 1 | Write response ready |
| cfg_araddr | input | ADDR_W | Read address |
| cfg_arvalid | input | 1 | Read address valid |
| cfg_arready | output | 1 | Read address ready |
| cfg_rdata | output | 32 | Read data |
| cfg_rresp | output | 2 | Read response (always OKAY) |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rready | input | 1 | Read data ready |
| ap_start | output | 1 | Start request to the accelerator |
| ap_done | input | 1 | Accelerator completion pulse |
| ap_ready | input | 1 | Accelerator has taken its inputs |
| ap_idle | input | 1 | Accelerator idle |
| interrupt | output | 1 | Completion interrupt (latched done) |

## Verification
The assertions check the routing invariants on every cycle: one-hot lane valid, that ready comes from the selected lane, and that TID 1 is absorbed in scalar mode. They also check that scalars only move after an accepted TID 1 beat, and that `ap_start` only falls and `interrupt` only rises after the matching accelerator signal. Some behaviour only the bench scenarios can show: the exact packing of multi-beat scalars, masking above the width, wrap-around, TLAST discarding a partial scalar, clear-on-read of the done bit, the auto-restart hold, and the disabled and stream-lane variants.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  // number of whole beats of width beat_w needed to hold w bits
  function automatic int unsigned beats_of(int unsigned w, int unsigned beat_w);
    return (w + beat_w - 1) / beat_w;
  endfunction

  typedef enum logic [1:0] {
    LANE1_STREAM = 2'd1,
    LANE1_SCALAR = 2'd2
  } lane1_mode_e;
endpackage

// File: rtl/tsr_route.sv
module tsr_route #(
  parameter int unsigned TID_W     = 3,
  parameter bit          ABSORB_T1 = 1'b1
) (
  input  logic                  s_tvalid,
  input  logic [TID_W-1:0]      s_tid,
  output logic                  s_tready,
  output logic [2**TID_W-1:0]   m_tvalid,
  input  logic [2**TID_W-1:0]   m_tready,
  output logic                  t1_fire
);
  localparam int unsigned LANES = 2**TID_W;

  logic to_scalar;

  always_comb begin
    to_scalar = ABSORB_T1 && (s_tid == TID_W'(1));
    m_tvalid  = '0;
    s_tready  = 1'b1;
    if (!to_scalar) begin
      m_tvalid[s_tid] = s_tvalid;
      s_tready        = m_tready[s_tid];
    end
    t1_fire = to_scalar && s_tvalid;
  end
endmodule

// File: rtl/tsr_scalar_unpack.sv
module tsr_scalar_unpack import tsr_pkg::*; #(
  parameter int unsigned DATA_W        = 128,
  parameter int unsigned NUM_SCALARS   = 2,
  parameter int unsigned SCALAR_MAX_W  = 256,
  parameter int unsigned SCALAR_WIDTHS [8] = '{160, 32, 32, 32, 32, 32, 32, 32}
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                fire,
  input  logic                                last,
  input  logic [DATA_W-1:0]                   data,
  output logic [NUM_SCALARS*SCALAR_MAX_W-1:0] scalar_o
);
  localparam int unsigned MAX_BEATS = SCALAR_MAX_W / DATA_W;
  localparam int unsigned BC_W      = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam int unsigned IX_W      = (NUM_SCALARS > 1) ? $clog2(NUM_SCALARS) : 1;

  function automatic logic [SCALAR_MAX_W-1:0] width_mask(int unsigned w);
    logic [SCALAR_MAX_W-1:0] m;
    m = '0;
    for (int i = 0; i < SCALAR_MAX_W; i++) if (i < w) m[i] = 1'b1;
    return m;
  endfunction

  logic [IX_W-1:0]                            idx_q, idx_d;
  logic [BC_W-1:0]                            bc_q, bc_d;
  logic [SCALAR_MAX_W-1:0]                    stage_q, stage_d, merged, cur_mask;
  logic [NUM_SCALARS-1:0][SCALAR_MAX_W-1:0]   scal_q, scal_d;
  logic                                       final_beat;

  // next-state
  always_comb begin
    final_beat = 1'b0;
    cur_mask   = '0;
    for (int k = 0; k < NUM_SCALARS; k++) begin
      if (idx_q == IX_W'(k)) begin
        final_beat = (bc_q == BC_W'(beats_of(SCALAR_WIDTHS[k], DATA_W) - 1));
        cur_mask   = width_mask(SCALAR_WIDTHS[k]);
      end
    end
    merged = stage_q;
    for (int b = 0; b < MAX_BEATS; b++) begin
      if (bc_q == BC_W'(b)) merged[b*DATA_W +: DATA_W] = data;
    end
    idx_d   = idx_q;
    bc_d    = bc_q;
    stage_d = stage_q;
    scal_d  = scal_q;
    if (fire) begin
      stage_d = merged;
      if (final_beat) begin
        scal_d[idx_q] = merged & cur_mask;
        idx_d = (idx_q == IX_W'(NUM_SCALARS - 1)) ? '0 : idx_q + 1'b1;
        bc_d  = '0;
      end else begin
        bc_d  = bc_q + 1'b1;
      end
      if (last) begin
        idx_d = '0;
        bc_d  = '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      bc_q    <= '0;
      stage_q <= '0;
      scal_q  <= '0;
    end else if (fire) begin
      idx_q   <= idx_d;
      bc_q    <= bc_d;
      stage_q <= stage_d;
      scal_q  <= scal_d;
    end
  end

  assign scalar_o = scal_q;
endmodule

// File: rtl/tsr_hs_ctrl.sv
module tsr_hs_ctrl #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic              ap_start,
  input  logic              ap_done,
  input  logic              ap_ready,
  input  logic              ap_idle,
  output logic              interrupt
);
  logic        start_q, start_d, auto_q, auto_d, done_q, done_d;
  logic        bval_q, bval_d, rval_q, rval_d;
  logic [31:0] rdat_q, rdat_d;
  logic        wr_hs, rd_hs, wr_ctl, rd_ctl;

  // next-state
  always_comb begin
    wr_hs  = awvalid && wvalid && !bval_q;
    rd_hs  = arvalid && !rval_q;
    wr_ctl = wr_hs && (awaddr == '0) && wstrb[0];
    rd_ctl = rd_hs && (araddr == '0);

    start_d = start_q;
    if (wr_ctl && wdata[0])                 start_d = 1'b1;
    else if (start_q && ap_ready && !auto_q) start_d = 1'b0;

    auto_d = wr_ctl ? wdata[7] : auto_q;

    done_d = done_q;
    if (ap_done)     done_d = 1'b1;
    else if (rd_ctl) done_d = 1'b0;

    rdat_d = rdat_q;
    if (rd_ctl)     rdat_d = {24'd0, auto_q, 3'd0, ap_ready, ap_idle, done_q, start_q};
    else if (rd_hs) rdat_d = '0;

    bval_d = wr_hs ? 1'b1 : (bready ? 1'b0 : bval_q);
    rval_d = rd_hs ? 1'b1 : (rready ? 1'b0 : rval_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      auto_q  <= 1'b0;
      done_q  <= 1'b0;
      bval_q  <= 1'b0;
      rval_q  <= 1'b0;
      rdat_q  <= '0;
    end else begin
      start_q <= start_d;
      auto_q  <= auto_d;
      done_q  <= done_d;
      bval_q  <= bval_d;
      rval_q  <= rval_d;
      if (rd_hs) rdat_q <= rdat_d;
    end
  end

  assign awready   = wr_hs;
  assign wready    = wr_hs;
  assign arready   = !rval_q;
  assign bvalid    = bval_q;
  assign rvalid    = rval_q;
  assign rdata     = rdat_q;
  assign ap_start  = start_q;
  assign interrupt = done_q;
endmodule

// File: rtl/tid_stream_router.sv
module tid_stream_router import tsr_pkg::*; #(
  parameter int unsigned DATA_W        = 128,
  parameter int unsigned TID_W         = 3,
  parameter int unsigned TID1_OUTPUT   = 2,
  parameter int unsigned NUM_SCALARS   = 2,
  parameter int unsigned SCALAR_MAX_W  = 256,
  parameter int unsigned SCALAR_WIDTHS [8] = '{160, 32, 32, 32, 32, 32, 32, 32},
  parameter bit          EN_AP_CTRL_HS = 1'b1,
  parameter int unsigned ADDR_W        = 12,
  localparam int unsigned NUM_LANES    = 2**TID_W,
  localparam int unsigned SC_BUS_W     = NUM_SCALARS * SCALAR_MAX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    s_tdata,
  input  logic [TID_W-1:0]     s_tid,
  input  logic                 s_tlast,
  input  logic                 s_tvalid,
  output logic                 s_tready,
  output logic [DATA_W-1:0]    m_tdata,
  output logic                 m_tlast,
  output logic [NUM_LANES-1:0] m_tvalid,
  input  logic [NUM_LANES-1:0] m_tready,
  output logic [SC_BUS_W-1:0]  scalar_o,
  input  logic [ADDR_W-1:0]    cfg_awaddr,
  input  logic                 cfg_awvalid,
  output logic                 cfg_awready,
  input  logic [31:0]          cfg_wdata,
  input  logic [3:0]           cfg_wstrb,
  input  logic                 cfg_wvalid,
  output logic                 cfg_wready,
  output logic [1:0]           cfg_bresp,
  output logic                 cfg_bvalid,
  input  logic                 cfg_bready,
  input  logic [ADDR_W-1:0]    cfg_araddr,
  input  logic                 cfg_arvalid,
  output logic                 cfg_arready,
  output logic [31:0]          cfg_rdata,
  output logic [1:0]           cfg_rresp,
  output logic                 cfg_rvalid,
  input  logic                 cfg_rready,
  output logic                 ap_start,
  input  logic                 ap_done,
  input  logic                 ap_ready,
  input  logic                 ap_idle,
  output logic                 interrupt
);
  localparam bit SCALAR_MODE = (TID1_OUTPUT == int'(LANE1_SCALAR));

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic t1_fire;

  tsr_route #(.TID_W(TID_W), .ABSORB_T1(SCALAR_MODE)) u_route (
    .s_tvalid (s_tvalid),
    .s_tid    (s_tid),
    .s_tready (s_tready),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .t1_fire  (t1_fire)
  );

  assign m_tdata = s_tdata;
  assign m_tlast = s_tlast;

  generate
    if (SCALAR_MODE) begin : g_scalar
      tsr_scalar_unpack #(
        .DATA_W(DATA_W), .NUM_SCALARS(NUM_SCALARS),
        .SCALAR_MAX_W(SCALAR_MAX_W), .SCALAR_WIDTHS(SCALAR_WIDTHS)
      ) u_unpack (
        .clk(clk), .rst_n(rst_int_n), .fire(t1_fire), .last(s_tlast),
        .data(s_tdata), .scalar_o(scalar_o)
      );
    end else begin : g_no_scalar
      assign scalar_o = '0;
    end

    if (EN_AP_CTRL_HS) begin : g_hs
      tsr_hs_ctrl #(.ADDR_W(ADDR_W)) u_hs (
        .clk(clk), .rst_n(rst_int_n),
        .awaddr(cfg_awaddr), .awvalid(cfg_awvalid), .awready(cfg_awready),
        .wdata(cfg_wdata), .wstrb(cfg_wstrb), .wvalid(cfg_wvalid), .wready(cfg_wready),
        .bvalid(cfg_bvalid), .bready(cfg_bready),
        .araddr(cfg_araddr), .arvalid(cfg_arvalid), .arready(cfg_arready),
        .rdata(cfg_rdata), .rvalid(cfg_rvalid), .rready(cfg_rready),
        .ap_start(ap_start), .ap_done(ap_done), .ap_ready(ap_ready),
        .ap_idle(ap_idle), .interrupt(interrupt)
      );
    end else begin : g_no_hs
      assign cfg_awready = 1'b0;
      assign cfg_wready  = 1'b0;
      assign cfg_bvalid  = 1'b0;
      assign cfg_arready = 1'b0;
      assign cfg_rdata   = '0;
      assign cfg_rvalid  = 1'b0;
      assign ap_start    = 1'b0;
      assign interrupt   = 1'b0;
    end
  endgenerate

  assign cfg_bresp = 2'b00;
  assign cfg_rresp = 2'b00;
endmodule

// File: rtl/tsr_chk.sv
module tsr_chk #(
  parameter int unsigned TID_W       = 3,
  parameter int unsigned TID1_OUTPUT = 2,
  parameter int unsigned SC_BUS_W    = 512
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  s_tvalid,
  input logic                  s_tready,
  input logic [TID_W-1:0]      s_tid,
  input logic [2**TID_W-1:0]   m_tvalid,
  input logic [2**TID_W-1:0]   m_tready,
  input logic [SC_BUS_W-1:0]   scalar_o,
  input logic                  ap_start,
  input logic                  ap_ready,
  input logic                  ap_done,
  input logic                  interrupt,
  input logic                  bvalid,
  input logic                  bready
);
  localparam bit T1_ROUTED = (TID1_OUTPUT != 2);

  // R1
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_tvalid));

  // R1
  lane_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && (T1_ROUTED || s_tid != TID_W'(1))) |-> m_tvalid[s_tid]);

  // R2
  lane_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && (T1_ROUTED || s_tid != TID_W'(1))) |-> (s_tready == m_tready[s_tid]));

  generate
    if (!T1_ROUTED) begin : g_sc
      // R3
      scalar_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tid == TID_W'(1)) |-> (s_tready && !m_tvalid[1]));

      // R5
      scalar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scalar_o) |-> $past(s_tvalid && s_tid == TID_W'(1)));
    end
  endgenerate

  // R8
  start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ap_start) |-> $past(ap_ready));

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(interrupt) |-> $past(ap_done));

  // R8
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
endmodule

bind tid_stream_router tsr_chk #(
  .TID_W(TID_W), .TID1_OUTPUT(TID1_OUTPUT), .SC_BUS_W(SC_BUS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
  .s_tid(s_tid), .m_tvalid(m_tvalid), .m_tready(m_tready), .scalar_o(scalar_o),
  .ap_start(ap_start), .ap_ready(ap_ready), .ap_done(ap_done),
  .interrupt(interrupt), .bvalid(cfg_bvalid), .bready(cfg_bready)
);

// File: tb/tid_stream_router_tb.sv
module tid_stream_router_tb;
  localparam int unsigned DW = 128;
  localparam int unsigned SW = 256;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic [DW-1:0]  s_tdata;
  logic [2:0]     s_tid;
  logic           s_tlast, s_tvalid;
  logic [7:0]     m_tready, alt_tready;
  logic [11:0]    awaddr, araddr;
  logic           awvalid, wvalid, bready, arvalid, rready;
  logic [31:0]    wdata;
  logic [3:0]     wstrb;
  logic           ap_done, ap_ready, ap_idle;

  logic           s_tready, m_tlast, awready, wready, bvalid, arready, rvalid, ap_start, interrupt;
  logic [DW-1:0]  m_tdata;
  logic [7:0]     m_tvalid;
  logic [2*SW-1:0] scalar_o;
  logic [1:0]     bresp, rresp;
  logic [31:0]    rdata;

  logic           a_s_tready, a_m_tlast, a_awready, a_wready, a_bvalid, a_arready, a_rvalid, a_ap_start, a_irq;
  logic [DW-1:0]  a_m_tdata;
  logic [7:0]     a_m_tvalid;
  logic [2*SW-1:0] a_scalar;
  logic [1:0]     a_bresp, a_rresp;
  logic [31:0]    a_rdata;

  tid_stream_router u_dut (
    .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tid(s_tid), .s_tlast(s_tlast),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .scalar_o(scalar_o),
    .cfg_awaddr(awaddr), .cfg_awvalid(awvalid), .cfg_awready(awready),
    .cfg_wdata(wdata), .cfg_wstrb(wstrb), .cfg_wvalid(wvalid), .cfg_wready(wready),
    .cfg_bresp(bresp), .cfg_bvalid(bvalid), .cfg_bready(bready),
    .cfg_araddr(araddr), .cfg_arvalid(arvalid), .cfg_arready(arready),
    .cfg_rdata(rdata), .cfg_rresp(rresp), .cfg_rvalid(rvalid), .cfg_rready(rready),
    .ap_start(ap_start), .ap_done(ap_done), .ap_ready(ap_ready), .ap_idle(ap_idle),
    .interrupt(interrupt)
  );

  tid_stream_router #(.TID1_OUTPUT(1), .EN_AP_CTRL_HS(1'b0)) u_alt (
    .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tid(s_tid), .s_tlast(s_tlast),
    .s_tvalid(s_tvalid), .s_tready(a_s_tready), .m_tdata(a_m_tdata), .m_tlast(a_m_tlast),
    .m_tvalid(a_m_tvalid), .m_tready(alt_tready), .scalar_o(a_scalar),
    .cfg_awaddr(awaddr), .cfg_awvalid(awvalid), .cfg_awready(a_awready),
    .cfg_wdata(wdata), .cfg_wstrb(wstrb), .cfg_wvalid(wvalid), .cfg_wready(a_wready),
    .cfg_bresp(a_bresp), .cfg_bvalid(a_bvalid), .cfg_bready(bready),
    .cfg_araddr(araddr), .cfg_arvalid(arvalid), .cfg_arready(a_arready),
    .cfg_rdata(a_rdata), .cfg_rresp(a_rresp), .cfg_rvalid(a_rvalid), .cfg_rready(rready),
    .ap_start(a_ap_start), .ap_done(ap_done), .ap_ready(ap_ready), .ap_idle(ap_idle),
    .interrupt(a_irq)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [2:0] tid, input logic [DW-1:0] d, input logic last);
    @(negedge clk);
    s_tid = tid; s_tdata = d; s_tlast = last; s_tvalid = 1'b1;
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic axi_wr(input logic [31:0] d);
    @(negedge clk);
    awaddr = '0; wdata = d; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1; bready = 1'b1;
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    @(negedge clk);
  endtask

  task automatic axi_rd(output logic [31:0] d);
    @(negedge clk);
    araddr = '0; arvalid = 1'b1; rready = 1'b1;
    @(negedge clk);
    d = rdata; arvalid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ready();
    @(negedge clk); ap_ready = 1'b1;
    @(negedge clk); ap_ready = 1'b0;
  endtask

  // routing vectors: {tid[19:17], lane ready[16:9], expected valid[8:1], expected s_tready[0]}
  localparam logic [19:0] VEC [8] = '{
    {3'd0, 8'hFF, 8'h01, 1'b1},
    {3'd0, 8'hFE, 8'h01, 1'b0},
    {3'd3, 8'h08, 8'h08, 1'b1},
    {3'd3, 8'hF7, 8'h08, 1'b0},
    {3'd7, 8'h80, 8'h80, 1'b1},
    {3'd1, 8'h00, 8'h00, 1'b1},
    {3'd5, 8'h20, 8'h20, 1'b1},
    {3'd6, 8'h00, 8'h40, 1'b0}
  };

  function automatic logic [SW-1:0] sc(input int k);
    return scalar_o[k*SW +: SW];
  endfunction

  localparam logic [DW-1:0] A = 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF;
  localparam logic [DW-1:0] B = 128'hB0B1B2B3_B4B5B6B7_B8B9BABB_BCBDBEBF;
  localparam logic [DW-1:0] C = 128'hC0C1C2C3_C4C5C6C7_C8C9CACB_CCCDCECF;
  localparam logic [DW-1:0] D = 128'hD0D1D2D3_D4D5D6D7_D8D9DADB_DCDDDEDF;
  localparam logic [DW-1:0] E = 128'hE0E1E2E3_E4E5E6E7_E8E9EAEB_ECEDEEEF;
  localparam logic [DW-1:0] F = 128'hF0F1F2F3_F4F5F6F7_F8F9FAFB_FCFDFEFF;
  localparam logic [DW-1:0] G = 128'h10111213_14151617_18191A1B_1C1D1E1F;
  localparam logic [DW-1:0] H = 128'h20212223_24252627_28292A2B_2C2D2E2F;
  localparam logic [DW-1:0] J = 128'h30313233_34353637_38393A3B_3C3D3E3F;

  function automatic logic [SW-1:0] pack2(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
    return {96'd0, hi[31:0], lo};
  endfunction

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; s_tdata = '0; s_tid = '0; s_tlast = 1'b0; s_tvalid = 1'b0;
    m_tready = '0; alt_tready = '0; awaddr = '0; araddr = '0; awvalid = 1'b0;
    wvalid = 1'b0; bready = 1'b0; arvalid = 1'b0; rready = 1'b0; wdata = '0;
    wstrb = '0; ap_done = 1'b0; ap_ready = 1'b0; ap_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 reset state
    chk(scalar_o == '0, "R7 scalars", sc(0), '0);
    chk(ap_start == 1'b0, "R7 ap_start", SW'(ap_start), '0);
    chk(interrupt == 1'b0, "R7 interrupt", SW'(interrupt), '0);
    chk(bvalid == 1'b0 && rvalid == 1'b0, "R7 bvalid/rvalid", SW'({bvalid, rvalid}), '0);

    // R1 R2 R3 routing table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      s_tid = VEC[i][19:17]; m_tready = VEC[i][16:9]; s_tdata = A; s_tlast = 1'b1; s_tvalid = 1'b1;
      #1;
      chk(m_tvalid == VEC[i][8:1], "R1/R3 lane valid", SW'(m_tvalid), SW'(VEC[i][8:1]));
      chk(s_tready == VEC[i][0], "R2/R3 input ready", SW'(s_tready), SW'(VEC[i][0]));
      chk(m_tdata == A && m_tlast == 1'b1, "R1 data/last broadcast", SW'(m_tdata), SW'(A));
      s_tvalid = 1'b0; s_tlast = 1'b0;
      #1;
      chk(m_tvalid == 8'h00, "R1 idle no valid", SW'(m_tvalid), '0);
    end
    m_tready = 8'hFF;

    // R11 stream lane 1 on the alternate instance
    @(negedge clk);
    s_tid = 3'd1; alt_tready = 8'h02; s_tvalid = 1'b1;
    #1;
    chk(a_m_tvalid == 8'h02 && a_s_tready == 1'b1, "R11 lane1 stream ready", SW'({a_m_tvalid, a_s_tready}), SW'({8'h02, 1'b1}));
    alt_tready = 8'hFD;
    #1;
    chk(a_m_tvalid == 8'h02 && a_s_tready == 1'b0, "R11 lane1 stream stall", SW'({a_m_tvalid, a_s_tready}), SW'({8'h02, 1'b0}));
    s_tvalid = 1'b0;

    // R4 R5 R6 scalar capture (scalar0 160 bits = 2 beats, scalar1 32 bits = 1 beat)
    beat(3'd1, A, 1'b0);
    chk(sc(0) == '0, "R5 no partial scalar0", sc(0), '0);
    beat(3'd0, J, 1'b0);
    chk(sc(0) == '0, "R5 other tid ignored", sc(0), '0);
    beat(3'd1, B, 1'b0);
    chk(sc(0) == pack2(A, B), "R4 scalar0 packed/masked", sc(0), pack2(A, B));
    chk(sc(1) == '0, "R5 scalar1 untouched", sc(1), '0);
    beat(3'd1, C, 1'b0);
    chk(sc(1) == SW'(C[31:0]), "R4 scalar1 masked", sc(1), SW'(C[31:0]));
    beat(3'd1, D, 1'b0);
    chk(sc(0) == pack2(A, B), "R6 wrap partial hidden", sc(0), pack2(A, B));
    beat(3'd1, E, 1'b0);
    chk(sc(0) == pack2(D, E), "R6 wrap to scalar0", sc(0), pack2(D, E));
    beat(3'd1, F, 1'b1);
    chk(sc(1) == SW'(F[31:0]), "R6 tlast commits full scalar", sc(1), SW'(F[31:0]));
    beat(3'd1, G, 1'b1);
    chk(sc(0) == pack2(D, E), "R6 tlast discards partial", sc(0), pack2(D, E));
    beat(3'd1, H, 1'b0);
    beat(3'd1, J, 1'b0);
    chk(sc(0) == pack2(H, J), "R6 restart at scalar0 after tlast", sc(0), pack2(H, J));
    chk(a_scalar == '0, "R11 stream mode has no scalars", a_scalar[SW-1:0], '0);

    // R8 R9 handshake registers
    axi_wr(32'h01);
    chk(ap_start == 1'b1, "R8 start set", SW'(ap_start), SW'(1));
    pulse_ready();
    chk(ap_start == 1'b0, "R8 start cleared by ready", SW'(ap_start), '0);
    axi_wr(32'h81);
    pulse_ready();
    chk(ap_start == 1'b1, "R8 auto_restart holds start", SW'(ap_start), SW'(1));
    axi_rd(rd);
    chk(rd == 32'h85, "R9 control readback", SW'(rd), SW'(32'h85));
    axi_wr(32'h00);
    chk(ap_start == 1'b1, "R8 writing zero keeps start", SW'(ap_start), SW'(1));
    pulse_ready();
    chk(ap_start == 1'b0, "R8 start cleared after auto off", SW'(ap_start), '0);
    @(negedge clk); ap_done = 1'b1;
    @(negedge clk); ap_done = 1'b0;
    chk(interrupt == 1'b1, "R9 done raises interrupt", SW'(interrupt), SW'(1));
    axi_rd(rd);
    chk(rd == 32'h06, "R9 done bit read", SW'(rd), SW'(32'h06));
    chk(interrupt == 1'b0, "R9 read clears interrupt", SW'(interrupt), '0);
    axi_rd(rd);
    chk(rd == 32'h04, "R9 done cleared on read", SW'(rd), SW'(32'h04));

    // R10 disabled handshake set on the alternate instance
    @(negedge clk);
    awvalid = 1'b1; wvalid = 1'b1; wdata = 32'h81; arvalid = 1'b1;
    #1;
    chk({a_awready, a_wready, a_arready} == 3'b000, "R10 no ready when disabled", SW'({a_awready, a_wready, a_arready}), '0);
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0; arvalid = 1'b0; ap_done = 1'b1;
    @(negedge clk);
    ap_done = 1'b0;
    chk({a_ap_start, a_irq, a_bvalid, a_rvalid} == 4'b0000, "R10 outputs held low", SW'({a_ap_start, a_irq, a_bvalid, a_rvalid}), '0);
    repeat (3) @(negedge clk);

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule